// File: doc/BRIEF.md
# Transmit Code Epoch Timing Adjuster

This block sets the start phase of the uplink spreading codes at a subscriber terminal. The goal is that those codes reach the remote despreader aligned to a common reference time. The block keeps one tick counter that spans a full code period. Each clock cycle is one chip cell, a quarter of a fast chip. From that counter it drives three strobes: a code epoch strobe, a fast-chip enable for the beam orthogonal code generator, and a slow-chip enable for the PN and user code generators. All three come from the same counter, so the access code epoch and the traffic code epochs cannot drift apart. Both chip rates also stay consistent with each other.

Timing corrections are signed counts of chip cells. A positive count inserts ticks into one code period, which delays the epoch. A negative count removes ticks, which advances the epoch. A mode input picks where corrections come from:

- a one-time coarse offset, taken from the access acquisition result;
- fine corrections, measured by the remote tracking loop;
- retention corrections, derived from the local downlink tracker.

One correction can wait at a time. It takes effect on the period that starts at the next epoch. Oversized requests are clamped, and replaced requests are flagged.

Top module: `code_epoch_adjuster`

## Requirements
- R1: While rst_ni is low, the tick counter is at phase 0, so epoch_o, fast_chip_en_o and slow_chip_en_o are all 1. aligned_o, sat_o and ovr_o are all 0.
- R2: With no correction, epoch_o pulses once every PERIOD = CELLS*FAST_PER_SLOW*SLOW_LEN ticks. fast_chip_en_o is 1 on ticks whose offset from the epoch is a multiple of CELLS. slow_chip_en_o is 1 on offsets that are a multiple of CELLS*FAST_PER_SLOW. Every epoch coincides with both enables.
- R3: An accepted correction N changes the length of one period to PERIOD+N ticks: a positive N delays the epoch, a negative N advances it. That period is the one starting at the first epoch after acceptance, and the following period is PERIOD again.
- R4: A correction with |N| > HALF = PERIOD/2 is applied as +HALF or -HALF, keeping its sign. sat_o pulses for exactly one cycle, the cycle after acceptance.
- R5: mode_i encoding: 0 is coarse, 1 is fine, 2 is retention and 3 is hold. Only the valid input that belongs to the current mode is accepted (coarse_valid_i, fine_valid_i or ret_valid_i). The other inputs, and every input in mode 3, change no period and raise no flag.
- R6: Only the first coarse offset after reset is accepted. Later coarse requests are ignored.
- R7: aligned_o rises at the epoch that ends the period the coarse offset was applied to. It stays high until reset.
- R8: At most one correction is pending. A correction accepted while another is still pending replaces it, and ovr_o pulses for one cycle. A correction accepted in the epoch cycle that consumes the pending one does not count as an overwrite: it becomes the next pending value.
- R9: No period is shorter than HALF ticks or longer than PERIOD+HALF ticks, so no strobe pattern collapses below one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip-cell clock, one tick per quarter fast chip |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Correction source: 0 coarse, 1 fine, 2 retention, 3 hold |
| coarse_valid_i | input | 1 | Coarse offset request |
| coarse_cells_i | input | CORR_W | Signed coarse offset in chip cells |
| fine_valid_i | input | 1 | Remote fine correction request |
| fine_cells_i | input | CORR_W | Signed fine correction in chip cells |
| ret_valid_i | input | 1 | Local retention correction request |
| ret_cells_i | input | CORR_W | Signed retention correction in chip cells |
| epoch_o | output | 1 | Code period start strobe |
| fast_chip_en_o | output | 1 | Orthogonal code chip advance enable |
| slow_chip_en_o | output | 1 | PN and user code chip advance enable |
| aligned_o | output | 1 | Coarse alignment has taken effect |
| sat_o | output | 1 | One-cycle pulse: last accepted correction was clamped |
| ovr_o | output | 1 | One-cycle pulse: pending correction was replaced |

## Verification
The assertions check the following on every cycle:

- every epoch coincides with both chip enables, and every slow-chip enable coincides with a fast-chip enable;
- every period length stays inside the HALF to PERIOD+HALF window;
- the flags pulse only after a request, and never in hold mode;
- aligned_o never falls.

Some behaviour can only be shown by the bench's scenarios. These are the exact period length produced by each signed correction and the clamp, and the order in which the pending slot is replaced or consumed. They also cover which sources each mode ignores, and the single-use coarse load. The bench sweeps the fine correction across and beyond the clamp range on a small code period.

// File: rtl/tca_pkg.sv
package tca_pkg;
  typedef enum logic [1:0] {
    MODE_COARSE = 2'd0,
    MODE_FINE   = 2'd1,
    MODE_RETAIN = 2'd2,
    MODE_HOLD   = 2'd3
  } tca_mode_e;
endpackage

// File: rtl/tca_strobe_gen.sv
module tca_strobe_gen #(
  parameter int DIV  = 4,
  parameter int PH_W = 8
) (
  input  logic [PH_W-1:0] phase_i,
  output logic            strobe_o
);
  generate
    if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      localparam int SH = $clog2(DIV);
      if (SH == 0) begin : g_every
        assign strobe_o = 1'b1;
      end else begin : g_mask
        assign strobe_o = (phase_i[SH-1:0] == '0);
      end
    end else begin : g_mod
      assign strobe_o = ((int'(phase_i) % DIV) == 0);
    end
  endgenerate
endmodule

// File: rtl/tca_corr_capture.sv
module tca_corr_capture
  import tca_pkg::*;
#(
  parameter int CORR_W = 10,
  parameter int OFF_W  = 10,
  parameter int HALF   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic                     coarse_valid_i,
  input  logic signed [CORR_W-1:0] coarse_cells_i,
  input  logic                     fine_valid_i,
  input  logic signed [CORR_W-1:0] fine_cells_i,
  input  logic                     ret_valid_i,
  input  logic signed [CORR_W-1:0] ret_cells_i,
  input  logic                     epoch_i,
  output logic                     take_o,
  output logic signed [OFF_W-1:0]  take_val_o,
  output logic                     take_coarse_o,
  output logic                     sat_o,
  output logic                     ovr_o
);
  logic                     sel_v, sel_coarse, clip;
  logic signed [CORR_W-1:0] sel_val;
  logic signed [OFF_W-1:0]  sel_clamped;
  logic                     coarse_used_q;
  logic                     pend_v_q, pend_coarse_q;
  logic signed [OFF_W-1:0]  pend_val_q;
  logic                     sat_q, ovr_q;
  int                       raw;

  always_comb begin
    sel_v      = 1'b0;
    sel_coarse = 1'b0;
    sel_val    = '0;
    unique case (tca_mode_e'(mode_i))
      MODE_COARSE: begin
        sel_v      = coarse_valid_i & ~coarse_used_q;
        sel_coarse = 1'b1;
        sel_val    = coarse_cells_i;
      end
      MODE_FINE: begin
        sel_v   = fine_valid_i;
        sel_val = fine_cells_i;
      end
      MODE_RETAIN: begin
        sel_v   = ret_valid_i;
        sel_val = ret_cells_i;
      end
      default: ;
    endcase
  end

  always_comb begin
    raw  = int'(sel_val);
    clip = 1'b0;
    if (raw > HALF) begin
      raw  = HALF;
      clip = 1'b1;
    end else if (raw < -HALF) begin
      raw  = -HALF;
      clip = 1'b1;
    end
    sel_clamped = OFF_W'(raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_used_q <= 1'b0;
      pend_v_q      <= 1'b0;
      pend_coarse_q <= 1'b0;
      pend_val_q    <= '0;
      sat_q         <= 1'b0;
      ovr_q         <= 1'b0;
    end else begin
      sat_q <= sel_v & clip;
      // slot consumed this cycle frees it; no overwrite then
      ovr_q <= sel_v & pend_v_q & ~epoch_i;
      if (sel_v && sel_coarse) coarse_used_q <= 1'b1;
      if (sel_v) begin
        pend_v_q      <= 1'b1;
        pend_val_q    <= sel_clamped;
        pend_coarse_q <= sel_coarse;
      end else if (epoch_i) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign take_o        = epoch_i & pend_v_q;
  assign take_val_o    = pend_val_q;
  assign take_coarse_o = pend_coarse_q;
  assign sat_o         = sat_q;
  assign ovr_o         = ovr_q;
endmodule

// File: rtl/tca_epoch_counter.sv
module tca_epoch_counter #(
  parameter int PERIOD = 64,
  parameter int PH_W   = 7,
  parameter int OFF_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_i,
  input  logic signed [OFF_W-1:0] take_val_i,
  input  logic                    take_coarse_i,
  output logic [PH_W-1:0]         phase_o,
  output logic                    epoch_o,
  output logic                    aligned_o
);
  logic [PH_W-1:0]         phase_q;
  logic signed [OFF_W-1:0] act_q;
  logic                    act_coarse_q, aligned_q;
  logic                    wrap;
  int                      last_tick;

  assign epoch_o   = (phase_q == '0);
  assign last_tick = PERIOD - 1 + int'(act_q);
  assign wrap      = (int'(phase_q) == last_tick);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= '0;
      act_q        <= '0;
      act_coarse_q <= 1'b0;
      aligned_q    <= 1'b0;
    end else begin
      phase_q <= wrap ? '0 : phase_q + 1'b1;
      // offset latched at epoch governs the period now starting
      if (epoch_o) begin
        act_q        <= take_i ? take_val_i : '0;
        act_coarse_q <= take_i & take_coarse_i;
      end
      if (wrap && act_coarse_q) aligned_q <= 1'b1;
    end
  end

  assign phase_o   = phase_q;
  assign aligned_o = aligned_q;
endmodule

// File: rtl/code_epoch_adjuster.sv
module code_epoch_adjuster #(
  parameter int CELLS         = 4,
  parameter int FAST_PER_SLOW = 4,
  parameter int SLOW_LEN      = 16,
  parameter int CORR_W        = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              coarse_valid_i,
  input  logic [CORR_W-1:0] coarse_cells_i,
  input  logic              fine_valid_i,
  input  logic [CORR_W-1:0] fine_cells_i,
  input  logic              ret_valid_i,
  input  logic [CORR_W-1:0] ret_cells_i,
  output logic              epoch_o,
  output logic              fast_chip_en_o,
  output logic              slow_chip_en_o,
  output logic              aligned_o,
  output logic              sat_o,
  output logic              ovr_o
);
  localparam int SLOW_CELLS = CELLS * FAST_PER_SLOW;
  localparam int PERIOD     = SLOW_CELLS * SLOW_LEN;
  localparam int HALF       = PERIOD / 2;
  localparam int PH_W       = $clog2(PERIOD + HALF);
  localparam int OFF_W      = PH_W + 1;

  logic                    take, take_coarse, epoch;
  logic signed [OFF_W-1:0] take_val;
  logic [PH_W-1:0]         phase;

  tca_corr_capture #(
    .CORR_W(CORR_W), .OFF_W(OFF_W), .HALF(HALF)
  ) u_capture (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode_i),
    .coarse_valid_i (coarse_valid_i),
    .coarse_cells_i (signed'(coarse_cells_i)),
    .fine_valid_i   (fine_valid_i),
    .fine_cells_i   (signed'(fine_cells_i)),
    .ret_valid_i    (ret_valid_i),
    .ret_cells_i    (signed'(ret_cells_i)),
    .epoch_i        (epoch),
    .take_o         (take),
    .take_val_o     (take_val),
    .take_coarse_o  (take_coarse),
    .sat_o          (sat_o),
    .ovr_o          (ovr_o)
  );

  tca_epoch_counter #(
    .PERIOD(PERIOD), .PH_W(PH_W), .OFF_W(OFF_W)
  ) u_counter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .take_val_i    (take_val),
    .take_coarse_i (take_coarse),
    .phase_o       (phase),
    .epoch_o       (epoch),
    .aligned_o     (aligned_o)
  );

  tca_strobe_gen #(.DIV(CELLS), .PH_W(PH_W)) u_fast (
    .phase_i (phase), .strobe_o (fast_chip_en_o)
  );

  tca_strobe_gen #(.DIV(SLOW_CELLS), .PH_W(PH_W)) u_slow (
    .phase_i (phase), .strobe_o (slow_chip_en_o)
  );

  assign epoch_o = epoch;
endmodule

// File: rtl/code_epoch_adjuster_chk.sv
module code_epoch_adjuster_chk #(
  parameter int PERIOD = 256,
  parameter int HALF   = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       coarse_valid_i,
  input logic       fine_valid_i,
  input logic       ret_valid_i,
  input logic       epoch_o,
  input logic       fast_chip_en_o,
  input logic       slow_chip_en_o,
  input logic       aligned_o,
  input logic       sat_o,
  input logic       ovr_o
);
  logic [31:0] since_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (epoch_o) begin
      since_q <= 32'd1;
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + 32'd1;
    end
  end

  assert_epoch_on_chips_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_o |-> (fast_chip_en_o && slow_chip_en_o));

  assert_slow_on_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_chip_en_o |-> fast_chip_en_o);

  assert_min_period_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epoch_o && seen_q) |-> (since_q >= 32'(HALF)));

  assert_max_period_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q <= 32'(PERIOD + HALF));

  assert_sat_needs_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> $past(coarse_valid_i || fine_valid_i || ret_valid_i));

  assert_ovr_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> $past(coarse_valid_i || fine_valid_i || ret_valid_i));

  assert_hold_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'd3) |-> (!sat_o && !ovr_o));

  assert_aligned_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |=> aligned_o);
endmodule

bind code_epoch_adjuster code_epoch_adjuster_chk #(
  .PERIOD(PERIOD), .HALF(HALF)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_i         (mode_i),
  .coarse_valid_i (coarse_valid_i),
  .fine_valid_i   (fine_valid_i),
  .ret_valid_i    (ret_valid_i),
  .epoch_o        (epoch_o),
  .fast_chip_en_o (fast_chip_en_o),
  .slow_chip_en_o (slow_chip_en_o),
  .aligned_o      (aligned_o),
  .sat_o          (sat_o),
  .ovr_o          (ovr_o)
);

// File: tb/code_epoch_adjuster_tb.sv
`timescale 1ns/1ps
module code_epoch_adjuster_tb;
  localparam int CELLS = 4;
  localparam int FPS   = 4;
  localparam int SLEN  = 4;
  localparam int CW    = 10;
  localparam int P     = CELLS * FPS * SLEN;
  localparam int H     = P / 2;
  localparam int SLOWC = CELLS * FPS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          cv = 1'b0, fv = 1'b0, rv = 1'b0;
  logic [CW-1:0] cc = '0, fc = '0, rc = '0;
  logic          epoch, fast_en, slow_en, aligned, sat, ovr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  code_epoch_adjuster #(
    .CELLS(CELLS), .FAST_PER_SLOW(FPS), .SLOW_LEN(SLEN), .CORR_W(CW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .coarse_valid_i(cv), .coarse_cells_i(cc),
    .fine_valid_i(fv), .fine_cells_i(fc),
    .ret_valid_i(rv), .ret_cells_i(rc),
    .epoch_o(epoch), .fast_chip_en_o(fast_en), .slow_chip_en_o(slow_en),
    .aligned_o(aligned), .sat_o(sat), .ovr_o(ovr)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v > H) return H;
    if (v < -H) return -H;
    return v;
  endfunction

  task automatic next_epoch();
    do @(negedge clk); while (!epoch);
  endtask

  // called at an epoch negedge; returns at the following one
  task automatic measure(output int len, output int nf, output int ns);
    len = 0; nf = 0; ns = 0;
    do begin
      if (fast_en) nf++;
      if (slow_en) ns++;
      len++;
      @(negedge clk);
    end while (!epoch);
  endtask

  // src: 0 coarse, 1 fine, 2 retention
  task automatic send(input int src, input int val, output bit s, output bit o);
    @(negedge clk);
    case (src)
      0: begin cv = 1'b1; cc = CW'(val); end
      1: begin fv = 1'b1; fc = CW'(val); end
      default: begin rv = 1'b1; rc = CW'(val); end
    endcase
    @(negedge clk);
    cv = 1'b0; fv = 1'b0; rv = 1'b0;
    s = sat; o = ovr;
  endtask

  task automatic expect_period(input int exp, input string req);
    int len, nf, ns;
    measure(len, nf, ns);
    check(len == exp, req, len, exp);
    check(nf == (exp + CELLS - 1) / CELLS, {req, " fast chips"}, nf, (exp + CELLS - 1) / CELLS);
    check(ns == (exp + SLOWC - 1) / SLOWC, {req, " slow chips"}, ns, (exp + SLOWC - 1) / SLOWC);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(epoch && fast_en && slow_en, "R1 strobes in reset", {epoch, fast_en, slow_en}, 7);
    check(!aligned && !sat && !ovr, "R1 flags in reset", {aligned, sat, ovr}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit s, o;
    int t_a, t_b;
    do_reset();

    // R2 nominal period and strobe spacing
    mode = 2'd0;
    next_epoch();
    expect_period(P, "R2 nominal");
    check(!aligned, "R7 not aligned before coarse", aligned, 0);

    // R3/R7 coarse advance
    send(0, -5, s, o);
    check(!s && !o, "R4 coarse flags", {s, o}, 0);
    next_epoch();
    check(!aligned, "R7 aligned low during adjusted period", aligned, 0);
    expect_period(P - 5, "R3 coarse advance");
    check(aligned, "R7 aligned at end of coarse period", aligned, 1);
    expect_period(P, "R3 single period only");

    // R6 second coarse ignored
    send(0, 7, s, o);
    next_epoch();
    expect_period(P, "R6 second coarse ignored");
    check(aligned, "R7 aligned stays high", aligned, 1);

    // R5 wrong-source requests ignored in fine mode
    mode = 2'd1;
    send(2, 9, s, o);
    check(!s && !o, "R5 retention in fine mode flags", {s, o}, 0);
    send(0, 40, s, o);
    check(!s && !o, "R5 coarse in fine mode flags", {s, o}, 0);
    next_epoch();
    expect_period(P, "R5 wrong sources ignored");

    // R3/R4 sweep fine corrections across the clamp range
    for (int c = -H - 8; c <= H + 8; c++) begin
      send(1, c, s, o);
      check(s == ((c > H) || (c < -H)), "R4 sat flag", s, (c > H) || (c < -H));
      check(!o, "R8 no overwrite single", o, 0);
      next_epoch();
      expect_period(P + clampv(c), "R3 fine period");
      expect_period(P, "R3 return to nominal");
    end

    // R8 replacement in the pending slot
    send(1, 3, s, o);
    check(!o, "R8 first no overwrite", o, 0);
    send(1, -6, s, o);
    check(o, "R8 overwrite pulse", o, 1);
    next_epoch();
    expect_period(P - 6, "R8 newer correction wins");
    expect_period(P, "R8 old correction dropped");

    // R8 acceptance in the consuming epoch cycle
    send(1, 4, s, o);
    next_epoch();
    t_a = cyc;
    fv = 1'b1; fc = CW'(-2);
    @(negedge clk);
    fv = 1'b0;
    check(!ovr, "R8 no overwrite on consuming epoch", ovr, 0);
    next_epoch();
    t_b = cyc;
    check(t_b - t_a == P + 4, "R8 consumed value applied", t_b - t_a, P + 4);
    expect_period(P - 2, "R8 epoch-cycle value queued");

    // R5 retention mode
    mode = 2'd2;
    send(1, 5, s, o);
    send(2, 12, s, o);
    check(!o, "R5 fine ignored in retention", o, 0);
    next_epoch();
    expect_period(P + 12, "R5 retention delay");
    send(2, 50, s, o);
    check(s, "R4 retention clamp flag", s, 1);
    next_epoch();
    expect_period(P + H, "R4 retention clamp");

    // R5 hold mode ignores everything
    mode = 2'd3;
    send(0, 9, s, o);
    check(!s && !o, "R5 hold coarse", {s, o}, 0);
    send(1, 99, s, o);
    check(!s && !o, "R5 hold fine", {s, o}, 0);
    send(2, -99, s, o);
    check(!s && !o, "R5 hold retention", {s, o}, 0);
    next_epoch();
    expect_period(P, "R5 hold period");

    // R6 reset re-arms coarse, R1 again
    mode = 2'd0;
    do_reset();
    check(!aligned, "R7 aligned cleared by reset", aligned, 0);
    send(0, 11, s, o);
    next_epoch();
    expect_period(P + 11, "R6 coarse accepted after reset");
    check(aligned, "R7 aligned after delayed coarse", aligned, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule